// File: doc/BRIEF.md
# Extended Data Memory Access Decoder

This block routes every data-space read or write issued by a processor core either to an on-chip RAM/peripheral window at the top of the address space or to the external memory bus. An access comes in one of two widths. A wide access carries a full 16-bit pointer. A short access carries an 8-bit register-indirect offset, and a page register supplies the upper byte. The block decodes the access combinationally. It raises exactly one of two select lines, internal or external. It also drives the external read/write strobe enables and two port-mode flags: one says the low port is acting as an address/data bus, the other says the high port is acting as an address bus.

A small mapping control register holds two bits. The disable bit comes out of reset at 1, which forces every access to the external bus. Once software writes it to 0, the window is open, and no later write can close it again; only reset does. The visibility bit chooses between two behaviours for internal accesses. With the bit at 0 the strobes stay quiet. With the bit at 1 the strobes and ports are driven, so internal traffic can be watched from outside. The lock is held by a two-state machine. `MAP_DISABLED` is the reset state. `MAP_ENABLED` is entered from `MAP_DISABLED` by the transition OPEN, which is a register write with bit 0 low. `MAP_ENABLED` has no exit and only loops on itself.

Top module: `xmem_decode`

## Requirements
- R1: After reset the register readback `cfg_rdata` is 8'h21: bit 0 (disable) is 1, bit 1 (visibility) is 0, bit 5 is 1, and all other bits are 0. The window is closed.
- R2: While the disable bit is 1, every access sets `ext_sel`=1 and `int_sel`=0, whatever its address and width.
- R3: A register write with bit 0 = 0 clears the disable bit. After that, writes with bit 0 = 1 leave it at 0 and the window stays open. Only reset sets the bit back to 1.
- R4: With the window open, a wide access (`acc_short`=0) selects internal exactly when `acc_ptr` lies in F700h..FFFFh. F6FFh and every lower address go external.
- R5: With the window open, a short access (`acc_short`=1) selects internal exactly when `acc_page` is F7h or above. The offset `acc_off` plays no part in the decision.
- R6: An internal access with the visibility bit at 0 keeps `strobe_rd` and `strobe_wr` at 0.
- R7: An internal access with the visibility bit at 1 drives the strobes and sets `p0_bus`=1 and `p2_bus`=!`acc_short`. This is the same port behaviour as an external access.
- R8: The visibility bit changes no output when the access falls outside the window or the window is closed.
- R9: An internal access with the visibility bit at 0 follows `ext_code_n`. When it is low, `p0_bus`=1 and `p2_bus`=!`acc_short`. When it is high, both flags are 0.
- R10: A short access never sets `p2_bus`.
- R11: `int_sel` and `ext_sel` are never 1 together. With `acc_req`=0, all six access outputs are 0.
- R12: When the strobes are active, `strobe_rd`=!`acc_wr` and `strobe_wr`=`acc_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the mapping control register |
| cfg_wdata | input | 8 | Write data: bit 1 visibility, bit 0 disable |
| cfg_rdata | output | 8 | Register readback |
| acc_req | input | 1 | Access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_short | input | 1 | 1 = paged 8-bit access, 0 = 16-bit pointer access |
| acc_ptr | input | 16 | Pointer for wide accesses |
| acc_page | input | 8 | Page register, upper byte for short accesses |
| acc_off | input | 8 | Register-indirect offset for short accesses |
| ext_code_n | input | 1 | External-access pin level (low = program fetched externally) |
| int_sel | output | 1 | Access served on chip |
| ext_sel | output | 1 | Access served by external memory |
| strobe_rd | output | 1 | External read strobe enable |
| strobe_wr | output | 1 | External write strobe enable |
| p0_bus | output | 1 | Low port in address/data bus mode |
| p2_bus | output | 1 | High port in address bus mode |

## Verification
A wrong lock state shows up as soon as the next access is decoded. If the machine sits in `MAP_DISABLED` when it should not, an in-window address goes external, and the reverse also holds. Because the decode is combinational, the error appears in the same cycle as the access. A lock that reopens can be seen in `cfg_rdata` bit 0 one clock after the offending write. Comparing at the window edges F6FFh/F700h, and F6h/F7h for the page, exposes any off-by-one in the comparators. A stuck visibility bit corrupts the strobe and port flags only on internal accesses, so both visibility settings are swept over in-window and out-of-window addresses.

// File: rtl/xmem_decode_pkg.sv
package xmem_decode_pkg;

    typedef enum logic {
        MAP_DISABLED = 1'b0,
        MAP_ENABLED  = 1'b1
    } map_state_e;

    typedef struct packed {
        logic int_sel;
        logic ext_sel;
        logic strobe_rd;
        logic strobe_wr;
        logic p0_bus;
        logic p2_bus;
    } route_t;

endpackage

// File: rtl/xmem_cfg_fsm.sv
module xmem_cfg_fsm
    import xmem_decode_pkg::*;
#(
    parameter int          CFG_W     = 8,
    parameter logic [7:0]  CFG_RESET = 8'h21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic             win_open,
    output logic             vis_on
);

    localparam int DIS_BIT = 0;
    localparam int VIS_BIT = 1;

    map_state_e state_q, state_d;
    logic       vis_q;

    // next-state logic: OPEN is the only transition
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MAP_DISABLED: if (cfg_we && !cfg_wdata[DIS_BIT]) state_d = MAP_ENABLED;
            MAP_ENABLED:  state_d = MAP_ENABLED;
            default:      state_d = MAP_DISABLED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MAP_DISABLED;
            vis_q   <= CFG_RESET[VIS_BIT];
        end else begin
            state_q <= state_d;
            if (cfg_we) vis_q <= cfg_wdata[VIS_BIT];
        end
    end

    // outputs
    always_comb begin
        win_open  = 1'b0;
        unique case (state_q)
            MAP_DISABLED: win_open = 1'b0;
            MAP_ENABLED:  win_open = 1'b1;
            default:      win_open = 1'b0;
        endcase
        vis_on    = vis_q;
        cfg_rdata = CFG_RESET[CFG_W-1:0];
        cfg_rdata[DIS_BIT] = !win_open;
        cfg_rdata[VIS_BIT] = vis_q;
    end

endmodule

// File: rtl/xmem_window.sv
module xmem_window #(
    parameter int               ADDR_W   = 16,
    parameter int               PAGE_W   = 8,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hF700,
    parameter logic [ADDR_W-1:0] WIN_LAST = 16'hFFFF
) (
    input  logic              acc_short,
    input  logic [ADDR_W-1:0] acc_ptr,
    input  logic [PAGE_W-1:0] acc_page,
    output logic              in_window
);

    localparam logic [PAGE_W-1:0] PAGE_BASE = WIN_BASE[ADDR_W-1:ADDR_W-PAGE_W];
    localparam logic [PAGE_W-1:0] PAGE_LAST = WIN_LAST[ADDR_W-1:ADDR_W-PAGE_W];

    logic hit_wide, hit_page;

    always_comb begin
        hit_wide  = (acc_ptr  >= WIN_BASE)  && (acc_ptr  <= WIN_LAST);
        hit_page  = (acc_page >= PAGE_BASE) && (acc_page <= PAGE_LAST);
        in_window = acc_short ? hit_page : hit_wide;
    end

endmodule

// File: rtl/xmem_route.sv
module xmem_route
    import xmem_decode_pkg::*;
(
    input  logic   acc_req,
    input  logic   acc_wr,
    input  logic   acc_short,
    input  logic   in_window,
    input  logic   win_open,
    input  logic   vis_on,
    input  logic   ext_code_n,
    output route_t route
);

    logic go_int, drive_pins;

    always_comb begin
        route      = '0;
        go_int     = win_open && in_window;
        drive_pins = !go_int || vis_on;
        if (acc_req) begin
            route.int_sel   = go_int;
            route.ext_sel   = !go_int;
            route.strobe_rd = drive_pins && !acc_wr;
            route.strobe_wr = drive_pins &&  acc_wr;
            if (drive_pins) begin
                route.p0_bus = 1'b1;
                route.p2_bus = !acc_short;
            end else begin
                route.p0_bus = !ext_code_n;
                route.p2_bus = !ext_code_n && !acc_short;
            end
        end
    end

endmodule

// File: rtl/xmem_decode.sv
module xmem_decode
    import xmem_decode_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                PAGE_W    = 8,
    parameter int                CFG_W     = 8,
    parameter logic [7:0]        CFG_RESET = 8'h21,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 16'hF700,
    parameter logic [ADDR_W-1:0] WIN_LAST  = 16'hFFFF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [CFG_W-1:0]         cfg_wdata,
    output logic [CFG_W-1:0]         cfg_rdata,
    input  logic                     acc_req,
    input  logic                     acc_wr,
    input  logic                     acc_short,
    input  logic [ADDR_W-1:0]        acc_ptr,
    input  logic [PAGE_W-1:0]        acc_page,
    input  logic [ADDR_W-PAGE_W-1:0] acc_off,
    input  logic                     ext_code_n,
    output logic                     int_sel,
    output logic                     ext_sel,
    output logic                     strobe_rd,
    output logic                     strobe_wr,
    output logic                     p0_bus,
    output logic                     p2_bus
);

    logic   win_open, vis_on, in_window, off_unused;
    route_t route;

    // the offset only forms the low address byte downstream
    assign off_unused = ^acc_off;

    xmem_cfg_fsm #(
        .CFG_W    (CFG_W),
        .CFG_RESET(CFG_RESET)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .win_open (win_open),
        .vis_on   (vis_on)
    );

    xmem_window #(
        .ADDR_W  (ADDR_W),
        .PAGE_W  (PAGE_W),
        .WIN_BASE(WIN_BASE),
        .WIN_LAST(WIN_LAST)
    ) u_win (
        .acc_short(acc_short),
        .acc_ptr  (acc_ptr),
        .acc_page (acc_page),
        .in_window(in_window)
    );

    xmem_route u_route (
        .acc_req   (acc_req),
        .acc_wr    (acc_wr),
        .acc_short (acc_short),
        .in_window (in_window),
        .win_open  (win_open),
        .vis_on    (vis_on),
        .ext_code_n(ext_code_n),
        .route     (route)
    );

    always_comb begin
        int_sel   = route.int_sel;
        ext_sel   = route.ext_sel;
        strobe_rd = route.strobe_rd;
        strobe_wr = route.strobe_wr;
        p0_bus    = route.p0_bus;
        p2_bus    = route.p2_bus;
    end

endmodule

// File: rtl/xmem_decode_chk.sv
module xmem_decode_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] cfg_rdata,
    input logic       acc_req,
    input logic       acc_wr,
    input logic       acc_short,
    input logic       int_sel,
    input logic       ext_sel,
    input logic       strobe_rd,
    input logic       strobe_wr,
    input logic       p2_bus
);

    AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(int_sel && ext_sel)); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_req |-> !(int_sel || ext_sel || strobe_rd || strobe_wr)); // R11

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[0] |=> !cfg_rdata[0]); // R3

    AST_CLOSED_EXTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[0] && acc_req) |-> (ext_sel && !int_sel)); // R2

    AST_HIDDEN_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (int_sel && !cfg_rdata[1]) |-> (!strobe_rd && !strobe_wr)); // R6

    AST_SHORT_NO_P2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_short) |-> !p2_bus); // R10

    AST_STROBE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req |-> !(strobe_rd && strobe_wr) && !(acc_wr && strobe_rd)); // R12

endmodule

bind xmem_decode xmem_decode_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_rdata(cfg_rdata),
    .acc_req  (acc_req),
    .acc_wr   (acc_wr),
    .acc_short(acc_short),
    .int_sel  (int_sel),
    .ext_sel  (ext_sel),
    .strobe_rd(strobe_rd),
    .strobe_wr(strobe_wr),
    .p2_bus   (p2_bus)
);

// File: tb/xmem_decode_bench.sv
module xmem_decode_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        acc_req = 1'b0, acc_wr = 1'b0, acc_short = 1'b0;
    logic [15:0] acc_ptr = '0;
    logic [7:0]  acc_page = '0, acc_off = '0;
    logic        ext_code_n = 1'b0;
    logic        int_sel, ext_sel, strobe_rd, strobe_wr, p0_bus, p2_bus;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    xmem_decode u_xmem_decode (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .acc_req(acc_req), .acc_wr(acc_wr),
        .acc_short(acc_short), .acc_ptr(acc_ptr), .acc_page(acc_page),
        .acc_off(acc_off), .ext_code_n(ext_code_n), .int_sel(int_sel),
        .ext_sel(ext_sel), .strobe_rd(strobe_rd), .strobe_wr(strobe_wr),
        .p0_bus(p0_bus), .p2_bus(p2_bus)
    );

    // {short, address (page:offset for short), expected in-window}
    localparam int NVEC = 11;
    localparam logic [17:0] VEC [NVEC] = '{
        {1'b0, 16'hF6FF, 1'b0}, {1'b0, 16'hF700, 1'b1}, {1'b0, 16'hFFFF, 1'b1},
        {1'b0, 16'h0000, 1'b0}, {1'b0, 16'h8123, 1'b0}, {1'b0, 16'hF800, 1'b1},
        {1'b1, 16'hF6FF, 1'b0}, {1'b1, 16'hF700, 1'b1}, {1'b1, 16'hFF00, 1'b1},
        {1'b1, 16'hFFFF, 1'b1}, {1'b1, 16'h00F8, 1'b0}
    };

    function automatic logic [5:0] outs();
        return {int_sel, ext_sel, strobe_rd, strobe_wr, p0_bus, p2_bus};
    endfunction

    function automatic logic [5:0] model(bit dis, bit vis, bit ea, bit wr, bit sh, bit inwin);
        bit it, drv, p0, p2;
        it  = !dis && inwin;
        drv = !it || vis;
        p0  = drv ? 1'b1 : !ea;
        p2  = drv ? !sh : (!ea && !sh);
        return {it, !it, drv && !wr, drv && wr, p0, p2};
    endfunction

    task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic cfg_write(logic [7:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic drive(bit sh, logic [15:0] a, bit wr, bit ea);
        @(negedge clk);
        acc_req = 1'b1; acc_short = sh; acc_wr = wr; ext_code_n = ea;
        if (sh) begin acc_page = a[15:8]; acc_off = a[7:0]; acc_ptr = 16'h0000; end
        else    begin acc_ptr = a; acc_page = 8'h00; acc_off = 8'h00; end
        #1;
    endtask

    task automatic sweep(bit dis, bit vis);
        for (int i = 0; i < NVEC; i++) begin
            for (int e = 0; e < 2; e++) begin
                for (int w = 0; w < 2; w++) begin
                    logic [5:0] exp;
                    string tag;
                    drive(VEC[i][17], VEC[i][16:1], bit'(w), bit'(e));
                    exp = model(dis, vis, bit'(e), bit'(w), VEC[i][17], VEC[i][0]);
                    // R2 closed, R4 wide, R5 short; R6-R10,R12 in the flags
                    if (dis)             tag = "R2";
                    else if (VEC[i][17]) tag = "R5";
                    else                 tag = "R4";
                    check(outs() == exp, tag, {10'd0, outs()}, {10'd0, exp});
                end
            end
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        #1;
        check(cfg_rdata == 8'h21, "R1", {8'd0, cfg_rdata}, 16'h0021);
        check(outs() == 6'b0, "R11 idle", {10'd0, outs()}, 16'h0);

        // window closed, visibility off/on: everything external (R2, R8)
        sweep(1'b1, 1'b0);
        acc_req = 1'b0;
        cfg_write(8'h23);
        #1;
        check(cfg_rdata == 8'h23, "R8 vis set while closed", {8'd0, cfg_rdata}, 16'h0023);
        sweep(1'b1, 1'b1);

        // OPEN with visibility on (R7), then hidden (R6, R9)
        acc_req = 1'b0;
        cfg_write(8'h02);
        #1;
        check(cfg_rdata == 8'h22, "R3 open", {8'd0, cfg_rdata}, 16'h0022);
        sweep(1'b0, 1'b1);
        acc_req = 1'b0;
        cfg_write(8'h00);
        sweep(1'b0, 1'b0);

        // R3: attempt to close again is ignored
        acc_req = 1'b0;
        cfg_write(8'h01);
        #1;
        check(cfg_rdata[0] == 1'b0, "R3 relock ignored", {15'd0, cfg_rdata[0]}, 16'h0);
        drive(1'b0, 16'hF700, 1'b1, 1'b1);
        check(int_sel && !ext_sel, "R3 window still open", {14'd0, int_sel, ext_sel}, 16'h2);
        // R6 hidden write strobe quiet, R9 pin high -> ports idle
        check(!strobe_wr && !p0_bus && !p2_bus, "R6 R9 hidden",
              {13'd0, strobe_wr, p0_bus, p2_bus}, 16'h0);
        // R5 offset irrelevant
        drive(1'b1, 16'hF700, 1'b0, 1'b0);
        check(int_sel, "R5 offset 00", {15'd0, int_sel}, 16'h1);
        drive(1'b1, 16'hF6FF, 1'b0, 1'b0);
        check(ext_sel && p0_bus && !p2_bus, "R10 short external",
              {13'd0, ext_sel, p0_bus, p2_bus}, 16'h6);
        // R12 direction on external read
        check(strobe_rd && !strobe_wr, "R12 read", {14'd0, strobe_rd, strobe_wr}, 16'h2);

        // R11 no request
        @(negedge clk); acc_req = 1'b0; #1;
        check(outs() == 6'b0, "R11 no request", {10'd0, outs()}, 16'h0);

        // only reset closes the window again (R3, R1)
        do_reset();
        #1;
        check(cfg_rdata == 8'h21, "R1 after second reset", {8'd0, cfg_rdata}, 16'h0021);
        drive(1'b0, 16'hFFFF, 1'b0, 1'b0);
        check(ext_sel && !int_sel, "R3 reset closes", {14'd0, int_sel, ext_sel}, 16'h1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule